// File: doc/BRIEF.md
# Interrupt Line Trigger Cell

One cell of an interrupt controller. It samples one asynchronous input line, brings it into the clock domain, and decides from a small stored configuration whether the line should raise a pending flag. Five trigger behaviours are available: rising edge, falling edge, either edge, active-high level and active-low level. Setting both mask bits turns the line off entirely.

The parent writes a 4-bit word with a single-cycle strobe. The lower three bits are kept inside the cell as its configuration. The top bit is a one-shot request that drops a latched edge event. The cell also exports the synchronised line value, so the parent can assemble a live-status view next to the pending view.

In edge mode the two mask bits enable individual edges. In level mode the same two bits choose the active polarity. The level-select bit decides which of these two meanings applies.

Top module: `irq_trig_cell`

## Requirements
- R1: While reset is asserted and directly after it, `pend_o` and `level_o` are 0. The stored configuration resets to both masks set with edge mode selected, so toggling the line before any write raises no pending flag.
- R2: `level_o` equals `line_i` delayed by SYNC_STAGES clock edges.
- R3: Word bit 2 masks rising events. In edge mode (bit 0 = 0) with bit 2 clear, a 0-to-1 change of the synchronised line sets `pend_o` one edge after `level_o` rises.
- R4: Word bit 1 masks falling events. In edge mode with bit 1 clear, a 1-to-0 change of the synchronised line sets `pend_o` one edge after `level_o` falls.
- R5: In edge mode with bits 1 and 2 both clear, either direction of change sets `pend_o`.
- R6: In edge mode a set `pend_o` holds until a write whose word bit 3 is 1. That write clears it at the write's clock edge.
- R7: In level mode (bit 0 = 1) with bit 2 clear and bit 1 set, `pend_o` equals the synchronised level delayed one edge. A clear written while the line is high leaves `pend_o` at 1.
- R8: In level mode with bit 1 clear and bit 2 set, `pend_o` equals the inverse of the synchronised level delayed one edge.
- R9: With bits 1 and 2 both set, no new pending state arises in either mode. A flag already latched in edge mode stays until cleared.
- R10: If a clear write lands on the same edge as a new enabled edge event, `pend_o` ends at 1.
- R11: A written configuration governs the pending logic from the clock edge after the write. The write's own edge still uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw asynchronous interrupt line |
| cfg_wr_i | input | 1 | One-cycle strobe that writes `cfg_i` |
| cfg_i | input | 4 | Bit 0 level select, bit 1 falling mask, bit 2 rising mask, bit 3 clear request |
| level_o | output | 1 | Synchronised line value |
| pend_o | output | 1 | Pending flag |

## Verification
The bench builds the cell with SYNC_STAGES = 3 instead of the default 2. This puts the synchroniser depth on the timing path of every check: `level_o` must still hold its old value after two edges, and `pend_o` must move one edge after `level_o`, so an off-by-one in the chain is caught. The directed scenarios place a clear write exactly on the edge where a detected transition is registered. They also issue a write and sample on the very next edge, which reaches the priority rule and the one-edge configuration latency.

// File: rtl/irq_trig_cell.sv
module irq_trig_cell #(
  parameter int       SYNC_STAGES = 2,
  parameter logic [2:0] CFG_RESET = 3'b110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       cfg_wr_i,
  input  logic [3:0] cfg_i,
  output logic       level_o,
  output logic       pend_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain;
  logic [2:0]       cfg_q;
  logic             lvl_mode, mask_fe, mask_re, clr;
  logic             prev, rise, fall, hit_edge, hit_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN-2:0], line_i};

  assign level_o = chain[SYNC_STAGES-1];
  assign prev    = chain[SYNC_STAGES];
  assign rise    = level_o & ~prev;
  assign fall    = ~level_o & prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_wr_i) cfg_q <= cfg_i[2:0];

  assign lvl_mode = cfg_q[0];
  assign mask_fe  = cfg_q[1];
  assign mask_re  = cfg_q[2];
  assign clr      = cfg_wr_i & cfg_i[3];

  assign hit_edge = (rise & ~mask_re) | (fall & ~mask_fe);
  assign hit_lvl  = (level_o & ~mask_re) | (~level_o & ~mask_fe);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pend_o <= 1'b0;
    else if (lvl_mode) pend_o <= hit_lvl;
    else               pend_o <= hit_edge | (pend_o & ~clr);
endmodule

// File: rtl/irq_trig_cell_chk.sv
module irq_trig_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_i,
  input logic [3:0] cfg_i,
  input logic       level_o,
  input logic       pend_o
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sh <= 3'b110;
    else if (cfg_wr_i) sh <= cfg_i[2:0];

  always @(posedge clk)
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pend_o && !level_o);
    end

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sh[0]) && !$past(sh[2]) && $past(level_o) && !$past(level_o, 2)) |-> pend_o);

  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> ($past(sh[0]) || ($past(cfg_wr_i) && $past(cfg_i[3]))));

  assert_level_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sh) == 3'b011) |-> (pend_o == $past(level_o)));

  assert_level_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sh) == 3'b101) |-> (pend_o == !$past(level_o)));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> ($past(sh[2:1]) != 2'b11));
endmodule

bind irq_trig_cell irq_trig_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_i(cfg_i),
  .level_o(level_o), .pend_o(pend_o)
);

// File: tb/irq_trig_cell_tb.sv
`timescale 1ns/1ps
module irq_trig_cell_tb;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [3:0] cfg_i = 4'h0;
  logic       level_o, pend_o;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_trig_cell #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .cfg_wr_i(cfg_wr_i),
    .cfg_i(cfg_i), .level_o(level_o), .pend_o(pend_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    cfg_i = v; cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(pend_o, 1'b0, "R1 pend in reset");
    chk(level_o, 1'b0, "R1 level in reset");
    rst_n = 1'b1;
    wait_n(1);
    chk(pend_o, 1'b0, "R1 pend after reset");
    line_i = 1'b1; wait_n(SYNC + 2);
    line_i = 1'b0; wait_n(SYNC + 2);
    chk(pend_o, 1'b0, "R1 default config masked");
  endtask

  task automatic t_latency;
    line_i = 1'b1;
    wait_n(SYNC - 1);
    chk(level_o, 1'b0, "R2 level before depth");
    wait_n(1);
    chk(level_o, 1'b1, "R2 level at depth");
    line_i = 1'b0;
    wait_n(SYNC);
    chk(level_o, 1'b0, "R2 level falls at depth");
    wait_n(2);
  endtask

  task automatic t_rise;
    wr(4'b0010);
    line_i = 1'b1;
    wait_n(SYNC);
    chk(pend_o, 1'b0, "R3 not yet pending");
    wait_n(1);
    chk(pend_o, 1'b1, "R3 rise sets pending");
    line_i = 1'b0; wait_n(SYNC + 2);
    chk(pend_o, 1'b1, "R6 edge pending latched");
    wr(4'b1010);
    chk(pend_o, 1'b0, "R6 clear write drops pending");
  endtask

  task automatic t_fall;
    wr(4'b0100);
    line_i = 1'b1; wait_n(SYNC + 2);
    chk(pend_o, 1'b0, "R4 rise masked");
    line_i = 1'b0; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R4 fall sets pending");
    wr(4'b1100);
    chk(pend_o, 1'b0, "R6 clear after fall");
  endtask

  task automatic t_both;
    wr(4'b0000);
    line_i = 1'b1; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R5 rise in both-edge mode");
    wr(4'b1000);
    chk(pend_o, 1'b0, "R5 cleared");
    line_i = 1'b0; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R5 fall in both-edge mode");
    wr(4'b1000);
  endtask

  task automatic t_level_hi;
    wr(4'b0011);
    chk(pend_o, 1'b0, "R7 low line inactive");
    line_i = 1'b1; wait_n(SYNC);
    chk(pend_o, 1'b0, "R7 one edge behind level");
    wait_n(1);
    chk(pend_o, 1'b1, "R7 follows high level");
    wr(4'b1011);
    chk(pend_o, 1'b1, "R7 clear while active no effect");
    wait_n(2);
    chk(pend_o, 1'b1, "R7 still active");
    line_i = 1'b0; wait_n(SYNC + 1);
    chk(pend_o, 1'b0, "R7 drops with level");
  endtask

  task automatic t_level_lo;
    wr(4'b0101);
    chk(pend_o, 1'b0, "R11 old config on write edge");
    wait_n(1);
    chk(pend_o, 1'b1, "R8 low level active");
    line_i = 1'b1; wait_n(SYNC + 1);
    chk(pend_o, 1'b0, "R8 high level inactive");
    line_i = 1'b0; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R8 low level again");
  endtask

  task automatic t_mask;
    wr(4'b0111);
    wait_n(2);
    chk(pend_o, 1'b0, "R9 level mode masked");
    wr(4'b0000);
    line_i = 1'b1; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R9 setup edge pending");
    wr(4'b0110);
    line_i = 1'b0; wait_n(SYNC + 2);
    chk(pend_o, 1'b1, "R9 latched kept when masked");
    wr(4'b1110);
    chk(pend_o, 1'b0, "R9 cleared");
    line_i = 1'b1; wait_n(SYNC + 2);
    line_i = 1'b0; wait_n(SYNC + 2);
    chk(pend_o, 1'b0, "R9 no new pending when masked");
  endtask

  task automatic t_race;
    wr(4'b0010);
    line_i = 1'b1; wait_n(SYNC + 1);
    chk(pend_o, 1'b1, "R10 setup pending");
    line_i = 1'b0; wait_n(SYNC + 2);
    line_i = 1'b1; wait_n(SYNC);
    wr(4'b1010);
    chk(pend_o, 1'b1, "R10 event beats clear");
    wr(4'b1010);
    chk(pend_o, 1'b0, "R6 plain clear after race");
  endtask

  initial begin
    wait_n(4);
    t_reset;
    t_latency;
    t_rise;
    t_fall;
    t_both;
    t_level_hi;
    t_level_lo;
    t_mask;
    t_race;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule